// File: doc/BRIEF.md
# GPIO Sample Capture and Pattern Playback Engine

This block links a small group of general-purpose pins to a word-wide FIFO interface. In capture mode it reads 1, 2 or 4 data pins once per sampling strobe. It packs the samples least-significant first into 32-bit words and pushes each finished word toward a FIFO. In playback mode it takes 32-bit words from a first-word-fall-through FIFO and drives their samples onto the data pins, one sample per strobe.

The sampling strobe comes from one of two sources. The first is an external clock on one of seven low GPIO lines. That line passes through a two-flop synchronizer and a rising-edge detector. One of the upper three lines can be replaced by an internally generated DDS clock. The second source is an internal divider that gives one strobe every N+1 system clocks. In playback, the divided clock can also be driven out on a chosen GPIO line. Mode codes other than capture and playback leave the engine idle. Both error flags are sticky while the engine is active and clear when it goes idle.

Top module: `pin_stream_engine`

## Requirements
- R1: With `cfg_mode` 00 or 10 the engine is idle. No word is pushed, no word is popped, `pat_out` reads 0 and `clk_out_en` reads 0, whatever the strobe sources do.
- R2: `cfg_width` 00 and 11 select 1-bit samples from pin bit 0. Code 01 selects 2-bit samples from bits [1:0]. Code 10 selects 4-bit samples from bits [3:0]. Pin bits above the selected width are ignored in capture and driven 0 in playback.
- R3: In capture mode (`cfg_mode` 01), sample k of a word occupies bits [k*w+w-1 : k*w]. After 32/w samples (32, 16 or 8), `cap_push` pulses for one cycle with the word on `cap_data`.
- R4: If `cap_full` is high when a word completes, that word is dropped with no push, and `overrun` is set. `overrun` stays set while capture mode stays on.
- R5: In playback mode (`cfg_mode` 11), the first strobe of each word pops one word with `gen_pop`. Each strobe loads the next sample of the word, least-significant first, into the registered `pat_out`.
- R6: If the FIFO is empty when a new word is needed, there is no pop, `pat_out` keeps its value, and `underrun` is set. The next strobe retries the pop.
- R7: With `cfg_ext_clk` = 1, the strobe is a rising edge on `gpio_clk_in[cfg_clk_sel]` for selects 0 to 6. Select 7 picks no line. The sampled data or the new `pat_out` takes effect within three system clocks of the edge.
- R8: With `cfg_dds_en` = 1 in an active mode, `dds_clk_in` replaces GPIO line 4+`cfg_dds_pin` for `cfg_dds_pin` 0 to 2, and code 3 replaces no line. With `cfg_dds_en` = 0, `dds_clk_in` has no effect.
- R9: With `cfg_ext_clk` = 0, a strobe occurs every `cfg_div`+1 system clocks. In playback, `clk_out[cfg_clk_sel]` carries a clock that is high for the first floor((N+1)/2) cycles of each period, and `clk_out_en` is one-hot on that line. Select 7 drives no line.
- R10: `overrun` and `underrun` clear when the engine goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_mode | input | 2 | 01 capture, 11 playback, other codes idle |
| cfg_width | input | 2 | Sample width code |
| cfg_ext_clk | input | 1 | 1: external strobe source, 0: internal divider |
| cfg_clk_sel | input | 3 | Strobe input line, or divided-clock output line |
| cfg_dds_en | input | 1 | Route the DDS clock onto an upper GPIO line |
| cfg_dds_pin | input | 2 | Target line 4+code for the DDS clock; code 3 means none |
| cfg_div | input | 16 | Divider value N (period N+1) |
| gpio_clk_in | input | 7 | GPIO lines usable as clock inputs |
| dds_clk_in | input | 1 | Internally generated DDS clock |
| smp_pins | input | 4 | Data pins read in capture mode |
| cap_full | input | 1 | Capture FIFO full |
| cap_push | output | 1 | Capture FIFO push strobe |
| cap_data | output | 32 | Packed capture word |
| gen_data | input | 32 | Playback FIFO head word (fall-through) |
| gen_empty | input | 1 | Playback FIFO empty |
| gen_pop | output | 1 | Playback FIFO pop |
| pat_out | output | 4 | Playback data pins |
| clk_out | output | 7 | Divided clock per GPIO line |
| clk_out_en | output | 7 | Output enable per GPIO line |
| overrun | output | 1 | Sticky capture overrun |
| underrun | output | 1 | Sticky playback underrun |

## Verification
In capture, the strobe that completes a word can arrive in the same cycle as a full FIFO. That one edge must then drop the word, raise `overrun` and restart the sample index. The bench provokes this by holding `cap_full` high across a whole 8-sample word. It judges the result by the absent push, the set flag, and a clean next word once space returns. In playback, the word boundary can meet an empty FIFO. The bench starves the queue at the boundary and checks that `pat_out` holds while `underrun` rises, with no pop.

// File: rtl/pse_pkg.sv
package pse_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE_A  = 2'b00,
        MODE_CAPTURE = 2'b01,
        MODE_IDLE_B  = 2'b10,
        MODE_PLAY    = 2'b11
    } mode_e;

    // Sample width in bits for a width code (00 and 11 both mean one bit).
    function automatic logic [2:0] width_bits(input logic [1:0] code);
        case (code)
            2'b01:   return 3'd2;
            2'b10:   return 3'd4;
            default: return 3'd1;
        endcase
    endfunction

    function automatic logic [3:0] width_mask(input logic [1:0] code);
        case (code)
            2'b01:   return 4'b0011;
            2'b10:   return 4'b1111;
            default: return 4'b0001;
        endcase
    endfunction

endpackage

// File: rtl/pse_clk_src.sv
module pse_clk_src #(
    parameter int DIV_W = 16,
    parameter int NCLK  = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             play_mode,
    input  logic             ext_mode,
    input  logic [2:0]       clk_sel,
    input  logic             dds_en,
    input  logic [1:0]       dds_pin,
    input  logic [DIV_W-1:0] div_n,
    input  logic [NCLK-1:0]  gpio_clk_in,
    input  logic             dds_clk_in,
    output logic             strobe,
    output logic [NCLK-1:0]  clk_out,
    output logic [NCLK-1:0]  clk_out_en
);

    localparam int DDS_BASE = 4;
    localparam int SEL_SPAN = 8;

    typedef struct packed {
        logic             s1;
        logic             s2;
        logic             prev;
        logic [DIV_W-1:0] cnt;
        logic             divclk;
    } clk_st_t;

    clk_st_t st_d, st_q;
    logic [SEL_SPAN-1:0] cand;
    logic                picked;
    logic [DIV_W:0]      half;

    for (genvar g = 0; g < SEL_SPAN; g++) begin : g_cand
        if (g < NCLK) begin : g_line
            assign cand[g] = (en && dds_en && (int'(dds_pin) + DDS_BASE == g))
                             ? dds_clk_in : gpio_clk_in[g];
        end else begin : g_none
            assign cand[g] = 1'b0;
        end
    end

    assign picked = cand[clk_sel];
    assign half   = ({1'b0, div_n} + 1'b1) >> 1;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = picked & en & ext_mode;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
        if (!en || ext_mode) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == div_n) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.divclk = en && !ext_mode && ({1'b0, st_d.cnt} < half);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign strobe = en && (ext_mode ? (st_q.s2 && !st_q.prev)
                                    : (st_q.cnt == div_n));

    for (genvar g = 0; g < NCLK; g++) begin : g_out
        assign clk_out_en[g] = en && play_mode && !ext_mode && (int'(clk_sel) == g);
        assign clk_out[g]    = clk_out_en[g] && st_q.divclk;
    end

    p_clk_en_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clk_out_en));

    p_strobe_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ext_mode && strobe) |=> (!strobe || !ext_mode));

endmodule

// File: rtl/pse_packer.sv
module pse_packer
    import pse_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int SMP_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              strobe,
    input  logic [1:0]        width_code,
    input  logic [SMP_W-1:0]  pins,
    input  logic              cap_full,
    output logic              cap_push,
    output logic [WORD_W-1:0] cap_data,
    output logic              overrun
);

    localparam int IDX_W = $clog2(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [IDX_W-1:0]  idx;
        logic              push;
        logic [WORD_W-1:0] data;
        logic              ovr;
    } pack_st_t;

    pack_st_t r_d, r_q;
    logic [IDX_W-1:0]  last_idx;
    logic [IDX_W-1:0]  shamt;
    logic [SMP_W-1:0]  mask;
    logic [WORD_W-1:0] acc;

    always_comb begin
        mask = SMP_W'(width_mask(width_code));
        case (width_bits(width_code))
            3'd2: begin
                last_idx = IDX_W'(WORD_W / 2 - 1);
                shamt    = r_q.idx << 1;
            end
            3'd4: begin
                last_idx = IDX_W'(WORD_W / 4 - 1);
                shamt    = r_q.idx << 2;
            end
            default: begin
                last_idx = IDX_W'(WORD_W - 1);
                shamt    = r_q.idx;
            end
        endcase
        acc = r_q.word | (WORD_W'(pins & mask) << shamt);
    end

    always_comb begin
        r_d      = r_q;
        r_d.push = 1'b0;
        if (!en) begin
            r_d.word = '0;
            r_d.idx  = '0;
            r_d.ovr  = 1'b0;
        end else if (strobe) begin
            if (r_q.idx == last_idx) begin
                r_d.idx  = '0;
                r_d.word = '0;
                if (cap_full) begin
                    r_d.ovr = 1'b1;
                end else begin
                    r_d.push = 1'b1;
                    r_d.data = acc;
                end
            end else begin
                r_d.idx  = r_q.idx + 1'b1;
                r_d.word = acc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cap_push = r_q.push;
    assign cap_data = r_q.data;
    assign overrun  = r_q.ovr;

    p_push_not_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cap_push |-> !$past(cap_full));

    p_overrun_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && overrun) |=> (overrun || !en));

endmodule

// File: rtl/pse_unpacker.sv
module pse_unpacker
    import pse_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int SMP_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              strobe,
    input  logic [1:0]        width_code,
    input  logic [WORD_W-1:0] gen_data,
    input  logic              gen_empty,
    output logic              gen_pop,
    output logic [SMP_W-1:0]  pat_out,
    output logic              underrun
);

    localparam int IDX_W = $clog2(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [IDX_W-1:0]  idx;
        logic [SMP_W-1:0]  pat;
        logic              unr;
    } unpack_st_t;

    unpack_st_t r_d, r_q;
    logic [IDX_W-1:0]  last_idx;
    logic [IDX_W-1:0]  shamt;
    logic [SMP_W-1:0]  mask;
    logic [WORD_W-1:0] src;
    logic [SMP_W-1:0]  smp;

    always_comb begin
        mask = SMP_W'(width_mask(width_code));
        case (width_bits(width_code))
            3'd2: begin
                last_idx = IDX_W'(WORD_W / 2 - 1);
                shamt    = r_q.idx << 1;
            end
            3'd4: begin
                last_idx = IDX_W'(WORD_W / 4 - 1);
                shamt    = r_q.idx << 2;
            end
            default: begin
                last_idx = IDX_W'(WORD_W - 1);
                shamt    = r_q.idx;
            end
        endcase
        src = (r_q.idx == '0) ? gen_data : r_q.word;
        smp = SMP_W'(src >> shamt) & mask;
    end

    assign gen_pop = en && strobe && (r_q.idx == '0) && !gen_empty;

    always_comb begin
        r_d = r_q;
        if (!en) begin
            r_d = '0;
        end else if (strobe) begin
            if (r_q.idx == '0) begin
                if (gen_empty) begin
                    r_d.unr = 1'b1;
                end else begin
                    r_d.word = gen_data;
                    r_d.pat  = smp;
                    r_d.idx  = IDX_W'(1);
                end
            end else begin
                r_d.pat = smp;
                r_d.idx = (r_q.idx == last_idx) ? '0 : r_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign pat_out  = r_q.pat;
    assign underrun = r_q.unr;

    p_pop_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        gen_pop |-> !gen_empty);

    p_underrun_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && $rose(underrun)) |-> $stable(pat_out));

endmodule

// File: rtl/pin_stream_engine.sv
module pin_stream_engine
    import pse_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int SMP_W  = 4,
    parameter int DIV_W  = 16,
    parameter int NCLK   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic [1:0]        cfg_width,
    input  logic              cfg_ext_clk,
    input  logic [2:0]        cfg_clk_sel,
    input  logic              cfg_dds_en,
    input  logic [1:0]        cfg_dds_pin,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [NCLK-1:0]   gpio_clk_in,
    input  logic              dds_clk_in,
    input  logic [SMP_W-1:0]  smp_pins,
    input  logic              cap_full,
    output logic              cap_push,
    output logic [WORD_W-1:0] cap_data,
    input  logic [WORD_W-1:0] gen_data,
    input  logic              gen_empty,
    output logic              gen_pop,
    output logic [SMP_W-1:0]  pat_out,
    output logic [NCLK-1:0]   clk_out,
    output logic [NCLK-1:0]   clk_out_en,
    output logic              overrun,
    output logic              underrun
);

    logic active, cap_en, play_en, strobe;

    assign cap_en  = (mode_e'(cfg_mode) == MODE_CAPTURE);
    assign play_en = (mode_e'(cfg_mode) == MODE_PLAY);
    assign active  = cap_en || play_en;

    pse_clk_src #(.DIV_W(DIV_W), .NCLK(NCLK)) u_clk_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (active),
        .play_mode  (play_en),
        .ext_mode   (cfg_ext_clk),
        .clk_sel    (cfg_clk_sel),
        .dds_en     (cfg_dds_en),
        .dds_pin    (cfg_dds_pin),
        .div_n      (cfg_div),
        .gpio_clk_in(gpio_clk_in),
        .dds_clk_in (dds_clk_in),
        .strobe     (strobe),
        .clk_out    (clk_out),
        .clk_out_en (clk_out_en)
    );

    pse_packer #(.WORD_W(WORD_W), .SMP_W(SMP_W)) u_packer (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cap_en),
        .strobe    (strobe),
        .width_code(cfg_width),
        .pins      (smp_pins),
        .cap_full  (cap_full),
        .cap_push  (cap_push),
        .cap_data  (cap_data),
        .overrun   (overrun)
    );

    pse_unpacker #(.WORD_W(WORD_W), .SMP_W(SMP_W)) u_unpacker (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (play_en),
        .strobe    (strobe),
        .width_code(cfg_width),
        .gen_data  (gen_data),
        .gen_empty (gen_empty),
        .gen_pop   (gen_pop),
        .pat_out   (pat_out),
        .underrun  (underrun)
    );

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !$past(active)) |-> (!cap_push && !gen_pop && pat_out == '0));

    p_flags_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!active) |-> (!overrun && !underrun));

endmodule

// File: tb/pin_stream_engine_tb.sv
`timescale 1ns/1ps
module pin_stream_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode = 2'b00;
    logic [1:0]  cfg_width = 2'b00;
    logic        cfg_ext_clk = 1'b1;
    logic [2:0]  cfg_clk_sel = 3'd0;
    logic        cfg_dds_en = 1'b0;
    logic [1:0]  cfg_dds_pin = 2'd0;
    logic [15:0] cfg_div = 16'd0;
    logic [6:0]  gpio_clk_in = '0;
    logic        dds_clk_in = 1'b0;
    logic [3:0]  smp_pins = '0;
    logic        cap_full = 1'b0;
    logic        cap_push;
    logic [31:0] cap_data;
    logic [31:0] gen_data;
    logic        gen_empty;
    logic        gen_pop;
    logic [3:0]  pat_out;
    logic [6:0]  clk_out, clk_out_en;
    logic        overrun, underrun;

    int n_chk = 0;
    int n_err = 0;
    int push_cnt = 0;
    logic [31:0] last_word = '0;
    logic [31:0] q [8];
    int head = 0;
    int tail = 0;
    int drive_pin = 0;
    bit use_dds = 0;

    always #10 clk = ~clk;

    assign gen_empty = (head == tail);
    assign gen_data  = q[head % 8];

    pin_stream_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_width(cfg_width),
        .cfg_ext_clk(cfg_ext_clk), .cfg_clk_sel(cfg_clk_sel), .cfg_dds_en(cfg_dds_en),
        .cfg_dds_pin(cfg_dds_pin), .cfg_div(cfg_div), .gpio_clk_in(gpio_clk_in),
        .dds_clk_in(dds_clk_in), .smp_pins(smp_pins), .cap_full(cap_full),
        .cap_push(cap_push), .cap_data(cap_data), .gen_data(gen_data),
        .gen_empty(gen_empty), .gen_pop(gen_pop), .pat_out(pat_out),
        .clk_out(clk_out), .clk_out_en(clk_out_en), .overrun(overrun),
        .underrun(underrun)
    );

    always @(posedge clk) if (gen_pop) head <= head + 1;

    always @(negedge clk) if (cap_push) begin
        push_cnt  = push_cnt + 1;
        last_word = cap_data;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One external strobe edge; results are settled on return.
    task automatic tick(input logic [3:0] p);
        @(negedge clk);
        smp_pins = p;
        if (use_dds) dds_clk_in = 1'b1;
        else         gpio_clk_in[drive_pin] = 1'b1;
        repeat (3) @(negedge clk);
        if (use_dds) dds_clk_in = 1'b0;
        else         gpio_clk_in[drive_pin] = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic go_idle();
        @(negedge clk);
        cfg_mode = 2'b00;
        repeat (2) @(negedge clk);
    endtask

    // Width code and the word to capture, then to play back.
    localparam logic [33:0] VEC [4] = '{
        {2'b00, 32'hA5C3_0F96},
        {2'b01, 32'h1234_5678},
        {2'b10, 32'hDEAD_BEEF},
        {2'b11, 32'h8000_0001}
    };

    initial begin
        int w, spw, p0, h0, highs, rises;
        logic [3:0] m, s, prev_s;
        logic [31:0] word;
        logic prev_c;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset cap_push", {31'd0, cap_push}, 0);
        chk("R1 reset pat_out", {28'd0, pat_out}, 0);
        chk("R10 reset flags", {30'd0, overrun, underrun}, 0);
        chk("R1 reset clk_out_en", {25'd0, clk_out_en}, 0);

        cfg_ext_clk = 1'b1;
        cfg_clk_sel = 3'd3;
        drive_pin   = 3;

        for (int v = 0; v < 4; v++) begin
            cfg_width = VEC[v][33:32];
            word      = VEC[v][31:0];
            w   = (cfg_width == 2'b01) ? 2 : (cfg_width == 2'b10) ? 4 : 1;
            spw = 32 / w;
            m   = 4'((1 << w) - 1);
            // R3 capture, R2 pins above width carry garbage
            @(negedge clk);
            cfg_mode = 2'b01;
            p0 = push_cnt;
            for (int i = 0; i < spw; i++) begin
                s = 4'(word >> (i * w)) & m;
                tick(s | ~m);
            end
            chk("R3 one push per word", push_cnt - p0, 1);
            chk("R2 R3 packed word", last_word, word);
            go_idle();
            // R5 playback of the same word
            q[tail % 8] = word;
            tail++;
            h0 = head;
            @(negedge clk);
            cfg_mode = 2'b11;
            for (int i = 0; i < spw; i++) begin
                s = 4'(word >> (i * w)) & m;
                tick(4'h0);
                chk("R5 R2 pattern sample", {28'd0, pat_out}, {28'd0, s});
                prev_s = s;
            end
            chk("R5 one pop per word", head - h0, 1);
            // R6 starved at word boundary
            tick(4'h0);
            chk("R6 underrun set", {31'd0, underrun}, 1);
            chk("R6 pat_out held", {28'd0, pat_out}, {28'd0, prev_s});
            chk("R6 no pop when empty", head - h0, 1);
            go_idle();
            chk("R10 underrun cleared", {31'd0, underrun}, 0);
            chk("R1 idle pat_out zero", {28'd0, pat_out}, 0);
        end

        // R1: mode 10 ignores strobes and queued data
        q[tail % 8] = 32'hFFFF_FFFF;
        tail++;
        h0 = head;
        p0 = push_cnt;
        cfg_width = 2'b10;
        @(negedge clk);
        cfg_mode = 2'b10;
        for (int i = 0; i < 8; i++) tick(4'hF);
        chk("R1 idle no push", push_cnt - p0, 0);
        chk("R1 idle no pop", head - h0, 0);
        chk("R1 idle pat_out", {28'd0, pat_out}, 0);
        cfg_ext_clk = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 idle clk_out_en", {25'd0, clk_out_en}, 0);
        cfg_ext_clk = 1'b1;
        head = tail;

        // R4: word completes while FIFO full
        @(negedge clk);
        cfg_mode = 2'b01;
        cap_full = 1'b1;
        p0 = push_cnt;
        for (int i = 0; i < 8; i++) tick(4'h5);
        chk("R4 dropped word", push_cnt - p0, 0);
        chk("R4 overrun set", {31'd0, overrun}, 1);
        cap_full = 1'b0;
        for (int i = 0; i < 8; i++) tick(4'(i));
        chk("R4 next word pushed", push_cnt - p0, 1);
        chk("R4 next word clean", last_word, 32'h7654_3210);
        chk("R4 overrun sticky", {31'd0, overrun}, 1);
        go_idle();
        chk("R10 overrun cleared", {31'd0, overrun}, 0);

        // R7: select 7 picks no line, select 6 works
        @(negedge clk);
        cfg_mode = 2'b01;
        cfg_clk_sel = 3'd7;
        drive_pin = 6;
        p0 = push_cnt;
        for (int i = 0; i < 8; i++) tick(4'hA);
        chk("R7 select 7 inert", push_cnt - p0, 0);
        cfg_clk_sel = 3'd6;
        for (int i = 0; i < 8; i++) tick(4'hA);
        chk("R7 line 6 strobes", push_cnt - p0, 1);
        chk("R7 line 6 word", last_word, 32'hAAAA_AAAA);

        // R8: DDS clock routed onto line 5
        cfg_clk_sel = 3'd5;
        cfg_dds_en  = 1'b1;
        cfg_dds_pin = 2'd1;
        use_dds = 1;
        p0 = push_cnt;
        for (int i = 0; i < 8; i++) tick(4'h3);
        chk("R8 dds strobes", push_cnt - p0, 1);
        chk("R8 dds word", last_word, 32'h3333_3333);
        cfg_dds_en = 1'b0;
        for (int i = 0; i < 8; i++) tick(4'h3);
        chk("R8 dds ignored when off", push_cnt - p0, 1);
        use_dds = 0;
        go_idle();

        // R9: divider in capture, N=1 -> strobe every 2 clocks
        cfg_ext_clk = 1'b0;
        cfg_div = 16'd1;
        smp_pins = 4'h9;
        p0 = push_cnt;
        @(negedge clk);
        cfg_mode = 2'b01;
        repeat (20) @(negedge clk);
        chk("R9 divider strobe rate", push_cnt - p0, 1);
        chk("R9 divider word", last_word, 32'h9999_9999);
        go_idle();

        // R9: divided clock output, N=3, line 2
        cfg_div = 16'd3;
        cfg_clk_sel = 3'd2;
        @(negedge clk);
        cfg_mode = 2'b11;
        repeat (6) @(negedge clk);
        chk("R9 output enable", {25'd0, clk_out_en}, 32'h4);
        highs = 0;
        rises = 0;
        prev_c = clk_out[2];
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (clk_out[2]) highs++;
            if (clk_out[2] && !prev_c) rises++;
            prev_c = clk_out[2];
        end
        chk("R9 duty high cycles", highs, 8);
        chk("R9 period rises", rises, 4);
        chk("R9 other lines low", {25'd0, clk_out & 7'b1111011}, 0);
        cfg_clk_sel = 3'd7;
        repeat (2) @(negedge clk);
        chk("R9 select 7 no output", {25'd0, clk_out_en}, 0);
        go_idle();

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule